// File: doc/BRIEF.md
# Double-Buffered Sample Pipeline Controller

This block holds two small shift pipelines of converter samples, called half A and half B, and moves data through them under three asynchronous timing strobes. A level strobe picks the half that receives shifted data. A second level strobe picks the half that drives the read port. A shared latch-shift strobe does two jobs. On its falling edge, a sample latch in front of the pipelines captures either the live converter word or a value held in a test register. On its rising edge, the write-selected half shifts by one entry and takes the latched sample into entry 0.

All three strobes are brought into the system clock through a synchroniser and are edge-detected, so each strobe edge causes exactly one action. A small write-only register port sets the source of the sample latch, gates the strobe-driven latch clock and holds the test value. The same port can also fire the sample latch directly from software.

Top module: `pipe_bank_ctrl`

## Requirements
- R1: After reset, `sample_q` is 0, every entry of both halves reads 0, the test register is the source, and the strobe-driven latch clock is disabled.
- R2: A falling edge of `shift_strobe` loads the sample latch when the gate register holds 0xFF. The latch takes `adc_data` when bit 0 of the source register is 1, and the test value when that bit is 0.
- R3: A falling edge of `shift_strobe` leaves `sample_q` unchanged while the gate register holds any value other than 0xFF.
- R4: A register write to address 3 with bit 0 set loads the sample latch from the selected source, whatever the gate register holds.
- R5: A rising edge of `shift_strobe` shifts the write-selected half. Entry i takes entry i-1, entry 0 takes `sample_q`, and the other half is unchanged.
- R6: When `wsel_strobe` is high, shifts go to half A. When it is low, shifts go to half B.
- R7: `rd_data` shows entry `rd_idx` of half A while `rsel_strobe` is high, and of half B while it is low.
- R8: A strobe held at one level causes no further action. A `shift_strobe` held high for many cycles shifts exactly once.
- R9: The register addresses are 0 for the source register, 1 for the gate register, 2 for the test value and 3 for the software latch pulse. A write takes effect in the cycle where `reg_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wsel_strobe | input | 1 | Write-half select strobe (asynchronous) |
| shift_strobe | input | 1 | Latch-shift strobe (asynchronous) |
| rsel_strobe | input | 1 | Read-half select strobe (asynchronous) |
| adc_data | input | 8 | Live converter sample |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| rd_idx | input | 2 | Entry index for the read port |
| rd_data | output | 8 | Selected entry of the read-selected half |
| sample_q | output | 8 | Sample latch contents |

## Verification
The main test is a sweep of sixteen strobe cycles with distinct converter words. In this sweep the write-select pattern alternates in pairs. After each cycle, every entry of both halves is read back. This catches a swapped half, a wrong shift direction, and a shift that takes the new word instead of the previously latched one. Separate passes use the test source, gate values of 0x00 and 0x7F, and the software pulse. These passes show that the strobe clock is gated while the software path is not. A long hold of the strobe shows that a level is not taken as an edge.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
  localparam int unsigned REG_AW = 2;
  typedef enum logic [REG_AW-1:0] {
    RA_SRC   = 2'd0,
    RA_GATE  = 2'd1,
    RA_TEST  = 2'd2,
    RA_PULSE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pbc_sync_edge.sv
module pbc_sync_edge #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain_q, chain_d;
    logic              prev_q;
    always_comb chain_d = {chain_q[STAGES-2:0], async_in[b]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= chain_d;
        prev_q  <= chain_q[STAGES-1];
      end
    end
    assign level[b] = chain_q[STAGES-1];
    assign rise[b]  = chain_q[STAGES-1] & ~prev_q;
    assign fall[b]  = ~chain_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/pbc_regs.sv
module pbc_regs
  import pbc_pkg::*;
#(
  parameter int unsigned SW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [SW-1:0]     reg_wdata,
  output logic              src_real,
  output logic              gate_on,
  output logic [SW-1:0]     test_val,
  output logic              sw_pulse
);
  logic          src_q, src_d;
  logic [SW-1:0] gate_q, gate_d;
  logic [SW-1:0] test_q, test_d;
  logic          we_src, we_gate, we_test;

  always_comb begin
    we_src   = reg_wr && (reg_addr == RA_SRC);
    we_gate  = reg_wr && (reg_addr == RA_GATE);
    we_test  = reg_wr && (reg_addr == RA_TEST);
    sw_pulse = reg_wr && (reg_addr == RA_PULSE) && reg_wdata[0];
    src_d    = we_src  ? reg_wdata[0] : src_q;
    gate_d   = we_gate ? reg_wdata    : gate_q;
    test_d   = we_test ? reg_wdata    : test_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= 1'b0;
      gate_q <= '0;
      test_q <= '0;
    end else begin
      src_q  <= src_d;
      gate_q <= gate_d;
      test_q <= test_d;
    end
  end

  assign src_real = src_q;
  assign gate_on  = &gate_q;
  assign test_val = test_q;
endmodule

// File: rtl/pbc_half.sv
module pbc_half #(
  parameter int unsigned SW    = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic [SW-1:0]       din,
  input  logic [IW-1:0]       rd_idx,
  output logic [SW-1:0]       rd_data,
  output logic [DEPTH*SW-1:0] flat
);
  logic [SW-1:0] ent_q [DEPTH];
  logic [SW-1:0] ent_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) ent_d[i] = ent_q[i];
    if (shift_en) begin
      ent_d[0] = din;
      for (int i = 1; i < DEPTH; i++) ent_d[i] = ent_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
    end
  end

  assign rd_data = ent_q[rd_idx];
  for (genvar i = 0; i < DEPTH; i++) begin : g_flat
    assign flat[i*SW +: SW] = ent_q[i];
  end
endmodule

// File: rtl/pipe_bank_ctrl.sv
module pipe_bank_ctrl
  import pbc_pkg::*;
#(
  parameter int unsigned SW          = 8,
  parameter int unsigned DEPTH       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IW         = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wsel_strobe,
  input  logic              shift_strobe,
  input  logic              rsel_strobe,
  input  logic [SW-1:0]     adc_data,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [SW-1:0]     reg_wdata,
  input  logic [IW-1:0]     rd_idx,
  output logic [SW-1:0]     rd_data,
  output logic [SW-1:0]     sample_q
);
  logic [2:0] st_lv, st_rise, st_fall;
  logic       wsel_lv, rsel_lv, shift_rise, shift_fall;
  logic       src_real, gate_on, sw_pulse;
  logic [SW-1:0] test_val, samp_q, samp_d;
  logic          samp_en;
  logic [SW-1:0] rd_a, rd_b;
  logic [DEPTH*SW-1:0] half_a_flat, half_b_flat;

  pbc_sync_edge #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({rsel_strobe, shift_strobe, wsel_strobe}),
    .level(st_lv), .rise(st_rise), .fall(st_fall)
  );
  assign wsel_lv    = st_lv[0];
  assign shift_rise = st_rise[1];
  assign shift_fall = st_fall[1];
  assign rsel_lv    = st_lv[2];

  pbc_regs #(.SW(SW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .src_real(src_real), .gate_on(gate_on),
    .test_val(test_val), .sw_pulse(sw_pulse)
  );

  always_comb begin
    samp_en = (shift_fall && gate_on) || sw_pulse;
    samp_d  = samp_en ? (src_real ? adc_data : test_val) : samp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) samp_q <= '0;
    else        samp_q <= samp_d;
  end

  pbc_half #(.SW(SW), .DEPTH(DEPTH)) u_half_a (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_rise && wsel_lv),
    .din(samp_q), .rd_idx(rd_idx), .rd_data(rd_a), .flat(half_a_flat)
  );
  pbc_half #(.SW(SW), .DEPTH(DEPTH)) u_half_b (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_rise && !wsel_lv),
    .din(samp_q), .rd_idx(rd_idx), .rd_data(rd_b), .flat(half_b_flat)
  );

  assign rd_data  = rsel_lv ? rd_a : rd_b;
  assign sample_q = samp_q;
endmodule

// File: rtl/pbc_chk.sv
module pbc_chk #(
  parameter int unsigned SW    = 8,
  parameter int unsigned DEPTH = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                shift_rise,
  input logic                shift_fall,
  input logic                wsel_lv,
  input logic                gate_on,
  input logic                sw_pulse,
  input logic [SW-1:0]       sample_q,
  input logic [DEPTH*SW-1:0] half_a_flat,
  input logic [DEPTH*SW-1:0] half_b_flat
);
  a_r3_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!(shift_fall && gate_on) && !sw_pulse) |=> $stable(sample_q));

  a_r5_other_half_a: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_rise && wsel_lv) |=> ($stable(half_b_flat) &&
                                 half_a_flat[SW-1:0] == $past(sample_q)));

  a_r6_other_half_b: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_rise && !wsel_lv) |=> ($stable(half_a_flat) &&
                                  half_b_flat[SW-1:0] == $past(sample_q)));

  a_r8_no_shift_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_rise |=> ($stable(half_a_flat) && $stable(half_b_flat)));

  a_r8_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shift_rise, shift_fall}));
endmodule

bind pipe_bank_ctrl pbc_chk #(.SW(SW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_rise(shift_rise), .shift_fall(shift_fall),
  .wsel_lv(wsel_lv), .gate_on(gate_on), .sw_pulse(sw_pulse),
  .sample_q(sample_q), .half_a_flat(half_a_flat), .half_b_flat(half_b_flat)
);

// File: tb/pipe_bank_ctrl_tb.sv
module pipe_bank_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wsel = 1'b0, shs = 1'b0, rsel = 1'b0;
  logic [7:0] adc = '0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [1:0] rd_idx = '0;
  logic [7:0] rd_data, sample_q;

  int checks = 0, errors = 0;
  logic [7:0] ma [4];
  logic [7:0] mb [4];
  logic [7:0] msamp;
  logic m_real;
  logic [7:0] m_test;
  logic m_gate;

  always #4 clk = ~clk;

  pipe_bank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wsel_strobe(wsel), .shift_strobe(shs),
    .rsel_strobe(rsel), .adc_data(adc), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_idx(rd_idx), .rd_data(rd_data), .sample_q(sample_q)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 2'd0) m_real = d[0];
    if (a == 2'd1) m_gate = (d == 8'hFF);
    if (a == 2'd2) m_test = d;
    if (a == 2'd3 && d[0]) msamp = m_real ? adc : m_test;
  endtask

  task automatic strobe_rise();
    shs = 1'b1;
    waitn(6);
    if (wsel) begin
      for (int i = 3; i > 0; i--) ma[i] = ma[i-1];
      ma[0] = msamp;
    end else begin
      for (int i = 3; i > 0; i--) mb[i] = mb[i-1];
      mb[0] = msamp;
    end
  endtask

  task automatic strobe_fall();
    shs = 1'b0;
    waitn(6);
    if (m_gate) msamp = m_real ? adc : m_test;
  endtask

  task automatic check_all(input string req);
    chk(sample_q == msamp, {req, " sample"}, sample_q, msamp);
    for (int h = 0; h < 2; h++) begin
      rsel = h[0];
      waitn(5);
      for (int i = 0; i < 4; i++) begin
        rd_idx = i[1:0];
        #1;
        if (h == 1) chk(rd_data == ma[i], {req, " R7 half A"}, rd_data, ma[i]);
        else        chk(rd_data == mb[i], {req, " R7 half B"}, rd_data, mb[i]);
      end
    end
  endtask

  initial begin
    fork
      begin
        for (int i = 0; i < 4; i++) begin ma[i] = '0; mb[i] = '0; end
        msamp = '0; m_real = 1'b0; m_test = '0; m_gate = 1'b0;
        waitn(3);
        rst_n = 1'b1;
        waitn(2);
        check_all("R1 reset");

        // R3: gate closed, falling edge ignored
        wr_reg(2'd2, 8'h5A);
        strobe_rise();
        strobe_fall();
        check_all("R3 gate 0x00");

        // R2: gate open, test source
        wr_reg(2'd1, 8'hFF);
        strobe_rise();
        strobe_fall();
        check_all("R2 test source");

        // R2/R5/R6: real source sweep
        wr_reg(2'd0, 8'h01);
        for (int k = 0; k < 16; k++) begin
          wsel = k[0] ^ k[1];
          waitn(5);
          strobe_rise();
          adc = 8'(k * 17 + 3);
          strobe_fall();
          check_all("R5 R6 sweep");
        end

        // R3: gate partly set
        wr_reg(2'd1, 8'h7F);
        adc = 8'hE7;
        strobe_rise();
        strobe_fall();
        check_all("R3 gate 0x7F");

        // R4 / R9: software pulse from test register with gate closed
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd2, 8'hC3);
        wr_reg(2'd3, 8'h01);
        waitn(2);
        check_all("R4 sw pulse");

        // R8: long high level gives a single shift
        wsel = 1'b1;
        waitn(5);
        strobe_rise();
        waitn(40);
        check_all("R8 long hold");
        strobe_fall();
        check_all("R8 after hold");
      end
      begin
        waitn(20000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule